// File: doc/BRIEF.md
# Start-Stop Framed Bit Serializer

This block turns a parallel word, taken once per reference-clock period, into a serial stream of twelve bits per period. Each data slot begins with a high start bit and ends with a low stop bit. The guaranteed low-to-high transition at every slot boundary gives a receiver an embedded clock edge. When the controller selects sync mode, the slot instead carries a fixed pattern of six ones and then six zeros, so that a receiver can lock quickly.

The design runs on one fast clock. A bit-rate enable `bit_en` marks each serial bit time, twelve per reference period. The reference clock arrives as a level, `ref_clk`, that is sampled on enabled ticks. A slot starts on the tick at which `ref_clk` is first seen high after being low. The word is captured into a holding register on the rising or the falling reference edge, chosen by `edge_rise`. A word is always sent in the slot that starts after it was captured, so a capture never disturbs the slot in progress.

The output-enable input only gates what leaves the block. The serial machinery keeps running while the output is off. There is no tri-state pin: "not driven" is signalled by `drv_valid` low, and `ser_out` is then held at 0. The data input has no valid/ready handshake because the block takes a word every reference period and cannot apply back-pressure.

Top module: `ser_framer`

## Requirements
- R1: A data slot, as seen on `ser_out`, carries bit index 0 = 1 (start), indices 1..10 = `din[0]..din[9]` (least significant bit first), and index 11 = 0 (stop). Index 0 appears after the clock edge of the enabled tick at which `ref_clk` is sampled 1 while its previous enabled sample was 0.
- R2: The output advances by exactly one bit per clock edge that has `bit_en` = 1. On edges with `bit_en` = 0, `ser_out` and the slot position hold.
- R3: When `sync_mode` = 1 at the slot's start tick, the slot carries indices 0..5 = 1 and indices 6..11 = 0, whatever `din` holds.
- R4: `sync_mode` is sampled only at a slot's start tick. Changing it inside a slot does not alter that slot.
- R5: When `edge_rise` = 0, `din` is captured on the enabled tick at which `ref_clk` is sampled 0 after a previous sample of 1 (falling edge).
- R6: When `edge_rise` = 1, `din` is captured on the rising-edge start tick. A slot always carries the word held before its start tick, so a capture on that same tick goes to the following slot.
- R7: With `oe` = 0, `drv_valid` = 0 and `ser_out` = 0, and shifting continues, so the bits that follow when `oe` returns to 1 are those of the ongoing slot at their normal positions.
- R8: After reset, `drv_valid` and `ser_out` are 0 until the first slot starts. After a slot's stop bit, if no new rising edge arrives, `ser_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Serial bit-time enable, twelve per reference period |
| ref_clk | input | 1 | Reference clock level, sampled on enabled ticks |
| din | input | DATA_W (10) | Parallel data word |
| edge_rise | input | 1 | 1 = capture on rising reference edge, 0 = on falling edge |
| sync_mode | input | 1 | 1 = send sync pattern, 0 = send data slots |
| oe | input | 1 | Output enable |
| ser_out | output | 1 | Serial bit, 0 when not driven |
| drv_valid | output | 1 | 1 when the serial output is considered driven |

## Verification
Random words on every tick separate least-significant-bit-first order from reversed order, and a bit stuck high from one stuck low. Because `din` also changes between the capture and the next slot, the bench can tell whether the right capture edge was used and whether a slot took the word from the current tick or from the held one. `sync_mode` is switched at random ticks, including mid-slot, which separates sampling at the slot start from sampling at every bit. Random idle gaps in `bit_en` expose any shifting without an enable. Short `oe` drops and a trailing stall of the reference clock test that gating has no effect on internal progress and that the line idles low after the stop bit.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    CAP_FALL = 1'b0,
    CAP_RISE = 1'b1
  } cap_edge_e;

  typedef enum logic {
    SLOT_DATA = 1'b0,
    SLOT_SYNC = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/ser_edge_det.sv
module ser_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  output logic rise_tick,
  output logic fall_tick
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else if (tick) level_q <= level;
  end

  assign rise_tick = tick & level & ~level_q;
  assign fall_tick = tick & ~level & level_q;
endmodule

// File: rtl/ser_hold_reg.sv
module ser_hold_reg #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/ser_frame_build.sv
module ser_frame_build #(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic               sync_sel,
  input  logic [DATA_W-1:0]  word,
  output logic [FRAME_W-1:0] frame
);
  localparam int HALF = FRAME_W / 2;

  logic [FRAME_W-1:0] data_fr;
  logic [FRAME_W-1:0] sync_fr;

  // index 0 is sent first: start bit, payload LSB first, stop bit
  assign data_fr = {1'b0, word, 1'b1};

  for (genvar g = 0; g < FRAME_W; g++) begin : g_sync
    if (g < HALF) begin : g_one
      assign sync_fr[g] = 1'b1;
    end else begin : g_zero
      assign sync_fr[g] = 1'b0;
    end
  end

  assign frame = sync_sel ? sync_fr : data_fr;
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int FRAME_W = 12,
  localparam int POS_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic               start_sync,
  input  logic [FRAME_W-1:0] frame,
  output logic               bit_q,
  output logic [POS_W-1:0]   pos,
  output logic               kind_sync,
  output logic               running
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      bit_q     <= 1'b0;
      pos       <= LAST;
      kind_sync <= 1'b0;
      running   <= 1'b0;
    end else if (tick) begin
      if (start) begin
        bit_q     <= frame[0];
        sh        <= frame >> 1;
        pos       <= '0;
        kind_sync <= start_sync;
        running   <= 1'b1;
      end else if (pos != LAST) begin
        bit_q <= sh[0];
        sh    <= sh >> 1;
        pos   <= pos + 1'b1;
      end else begin
        bit_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_framer.sv
module ser_framer #(
  parameter int DATA_W  = 10,
  localparam int FRAME_W = DATA_W + 2,
  localparam int POS_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              ref_clk,
  input  logic [DATA_W-1:0] din,
  input  logic              edge_rise,
  input  logic              sync_mode,
  input  logic              oe,
  output logic              ser_out,
  output logic              drv_valid
);
  import ser_pkg::*;

  logic               rise_tick, fall_tick;
  logic               cap_now;
  logic [DATA_W-1:0]  held;
  logic [FRAME_W-1:0] next_frame;
  logic               bit_q;
  logic [POS_W-1:0]   bit_pos;
  logic               frame_sync;
  logic               started;
  cap_edge_e          cap_sel;
  slot_kind_e         kind_in;

  assign cap_sel = cap_edge_e'(edge_rise);
  assign kind_in = slot_kind_e'(sync_mode);

  ser_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .tick(bit_en), .level(ref_clk),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  assign cap_now = (cap_sel == CAP_RISE) ? rise_tick : fall_tick;

  ser_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(cap_now), .d(din), .q(held)
  );

  ser_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_build (
    .sync_sel(kind_in == SLOT_SYNC), .word(held), .frame(next_frame)
  );

  ser_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(bit_en), .start(rise_tick),
    .start_sync(kind_in == SLOT_SYNC), .frame(next_frame),
    .bit_q(bit_q), .pos(bit_pos), .kind_sync(frame_sync), .running(started)
  );

  assign drv_valid = oe & started;
  assign ser_out   = drv_valid & bit_q;
endmodule

// File: rtl/ser_framer_chk.sv
module ser_framer_chk #(
  parameter int FRAME_W = 12,
  localparam int POS_W  = $clog2(FRAME_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             oe,
  input logic             ser_out,
  input logic             drv_valid,
  input logic             rise_tick,
  input logic [POS_W-1:0] bit_pos,
  input logic             bit_q,
  input logic             frame_sync
);
  localparam int HALF = FRAME_W / 2;

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> (bit_q && bit_pos == '0)); // R1

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bit_pos) == FRAME_W - 1) |-> !bit_q); // R1

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bit_q) && $stable(bit_pos))); // R2

  AST_SYNC_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && int'(bit_pos) < HALF) |-> bit_q); // R3

  AST_SYNC_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && int'(bit_pos) >= HALF) |-> !bit_q); // R3

  AST_VALID_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_valid |-> oe); // R7

  AST_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_valid |-> !ser_out); // R7
endmodule

bind ser_framer ser_framer_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .oe(oe), .ser_out(ser_out),
  .drv_valid(drv_valid), .rise_tick(rise_tick), .bit_pos(bit_pos),
  .bit_q(bit_q), .frame_sync(frame_sync)
);

// File: tb/ser_framer_test.sv
module ser_framer_test;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF    = FRAME_W / 2;
  localparam int NFRAMES = 300;

  logic clk = 1'b0;
  logic rst_n, bit_en, ref_clk, edge_rise, sync_mode, oe;
  logic [DATA_W-1:0] din;
  logic ser_out, drv_valid;

  ser_framer #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ref_clk(ref_clk), .din(din),
    .edge_rise(edge_rise), .sync_mode(sync_mode), .oe(oe),
    .ser_out(ser_out), .drv_valid(drv_valid)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0]  m_hold = '0;
  logic [FRAME_W-1:0] m_frame = '0;
  bit m_ref_prev = 1'b0, m_started = 1'b0, m_sync = 1'b0;
  bit m_hold_fall = 1'b0, m_frame_fall = 1'b0, m_mode_chg = 1'b0;
  int m_pos = FRAME_W - 1;

  function automatic logic [FRAME_W-1:0] mk_frame(logic [DATA_W-1:0] w, bit s);
    logic [FRAME_W-1:0] f;
    if (s) begin
      for (int i = 0; i < FRAME_W; i++) f[i] = (i < HALF);
    end else begin
      f[0] = 1'b1;
      for (int i = 0; i < DATA_W; i++) f[i+1] = w[i];
      f[FRAME_W-1] = 1'b0;
    end
    return f;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one enabled bit time, then a random idle gap; entered and left at negedge
  task automatic do_tick(bit r);
    bit exp_bit;
    bit exp_v;
    string tag;
    logic held_out;
    ref_clk = r;
    bit_en  = 1'b1;
    if (r && !m_ref_prev) begin
      m_frame      = mk_frame(m_hold, sync_mode);
      m_sync       = sync_mode;
      m_frame_fall = m_hold_fall;
      m_mode_chg   = 1'b0;
      m_pos        = 0;
      m_started    = 1'b1;
      exp_bit      = m_frame[0];
    end else if (m_pos < FRAME_W - 1) begin
      m_pos++;
      exp_bit = m_frame[m_pos];
    end else begin
      exp_bit = 1'b0;
    end
    if ((edge_rise && r && !m_ref_prev) || (!edge_rise && !r && m_ref_prev)) begin
      m_hold      = din;
      m_hold_fall = !edge_rise;
    end
    m_ref_prev = r;
    @(negedge clk);
    bit_en = 1'b0;
    exp_v = oe && m_started;
    if (!m_started) tag = "R8";
    else if (!oe) tag = "R7";
    else if (m_pos == FRAME_W - 1 && !(r && m_pos == 0)) tag = (m_sync ? "R3" : "R1");
    else if (m_mode_chg) tag = "R4";
    else if (m_sync) tag = "R3";
    else if (m_pos >= 1 && m_pos <= DATA_W) tag = (m_frame_fall ? "R5" : "R6");
    else tag = "R1";
    check(ser_out === (exp_v ? exp_bit : 1'b0), tag, ser_out, exp_v ? exp_bit : 1'b0);
    check(drv_valid === exp_v, (m_started ? "R7" : "R8"), drv_valid, exp_v);
    held_out = ser_out;
    repeat ($urandom % 3) begin
      din = DATA_W'($urandom);
      @(negedge clk);
      check(ser_out === held_out, "R2", ser_out, held_out);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bit_en = 1'b0; ref_clk = 1'b0; din = '0;
    edge_rise = 1'b1; sync_mode = 1'b0; oe = 1'b1;
    repeat (3) @(negedge clk);
    check(ser_out === 1'b0, "R8", ser_out, 0);
    check(drv_valid === 1'b0, "R8", drv_valid, 0);
    rst_n = 1'b1;
    // no rising edge yet: output stays quiet
    for (int t = 0; t < 4; t++) do_tick(1'b0);

    for (int f = 0; f < NFRAMES; f++) begin
      if (f < 4) edge_rise = (f % 2 == 0);
      else if ($urandom % 4 == 0) edge_rise = ~edge_rise;
      for (int t = 0; t < FRAME_W; t++) begin
        if (f == 0 && t == 0) din = '1;
        else if (f == 1 && t == 6) din = '0;
        else if (f == 2 && t == 0) din = DATA_W'(10'h155);
        else din = DATA_W'($urandom);
        if (f >= 4 && $urandom % 8 == 0) begin
          sync_mode = ~sync_mode;
          if (t != 0) m_mode_chg = 1'b1;
        end
        oe = (f < 4) ? 1'b1 : ($urandom % 16 != 0);
        do_tick(t < HALF);
      end
    end

    // reference stalls low: after the stop bit the line stays 0
    oe = 1'b1;
    for (int t = 0; t < FRAME_W + 2; t++) do_tick(1'b0);
    check(ser_out === 1'b0, "R8", ser_out, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule